// File: doc/BRIEF.md
# Prioritized Power-State Sequencing Controller

This block is the mission-mode state machine of a power-management controller. A vector of trigger request lines comes in. Each cycle the lowest-numbered asserted line is taken as the only candidate. If that trigger is legal in the current power state, the block starts the matching power sequence on a sequence engine through a start/done handshake. The state register moves to the trigger's destination only when the engine reports completion.

Triggers have a fixed priority, and each has two attributes. An immediate trigger may abort a running sequence of lower priority. A deferred trigger is only considered when no sequence is running. A non-re-entrant trigger is dropped when the machine already sits in its destination state. The three immediate triggers lead to a terminal SAFE state. While a SAFE-bound sequence runs, all outputs are held at their powered-down values.

From the registered state the block drives the state code, an external enable-driver line and a vector of power-domain group enables. The masks that pick the MCU safety-island groups and the DDR retention groups are parameters.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the state is STANDBY (code 0). seq_start_o is 0, seq_code_o is 0, en_drv_o is 0 and dom_en_o is all zeros.
- R2: Only the lowest-index asserted trigger line is a candidate. If that trigger is not legal in the current state, nothing starts, even when a higher-index asserted line would be legal.
- R3: Triggers 0, 1 and 2 are immediate. Each is legal in STANDBY, ACTIVE, MCU_ONLY and RETENTION, leads to SAFE (code 5), and runs sequence code 1, 2 or 3 respectively.
- R4: Trigger 3 (off request) is legal in STANDBY, ACTIVE, MCU_ONLY and RETENTION. It leads to STANDBY with code 4. It is not re-entrant, so it is ignored while the state is already STANDBY.
- R5: Triggers 5, 6 and 7 are re-entrant in ACTIVE (code 1): they keep ACTIVE and run codes 6, 7 and 8. Triggers 8 and 9 are re-entrant in MCU_ONLY (code 2): they keep MCU_ONLY and run codes 9 and 10.
- R6: Trigger 4 moves ACTIVE to SOC_PWR_ERROR (code 3) with code 5. In SOC_PWR_ERROR only trigger 10 is legal. Trigger 10 moves ACTIVE or SOC_PWR_ERROR to MCU_ONLY with code 11.
- R7: Trigger 11 (on request) moves STANDBY, MCU_ONLY or RETENTION to ACTIVE with code 12, but only while mask_clr_i is 1. Trigger 12 moves ACTIVE to RETENTION (code 4) with code 13.
- R8: seq_start_o pulses in the cycle after a trigger is accepted. seq_code_o holds the code while the sequence runs and is 0 when idle. The state changes only on a clock edge where seq_done_i is 1 while a sequence runs.
- R9: A deferred trigger asserted while a sequence runs starts nothing. If it is still asserted, it is evaluated in the cycle after done.
- R10: An immediate trigger aborts a running sequence only when its index is lower than that of the running trigger. The aborted sequence does not change the state.
- R11: Outputs by state:
  - ACTIVE: en_drv_o is 1 and all groups are on.
  - MCU_ONLY and SOC_PWR_ERROR: en_drv_o is 1 and the groups equal MCU_GRP_MASK (default 0x03).
  - RETENTION: en_drv_o is 0 and the groups equal DDR_GRP_MASK (default 0x1C).
  - STANDBY: en_drv_o is 0 and all groups are off.
- R12: From the cycle a SAFE-bound sequence starts, en_drv_o is 0 and all groups are off. SAFE is terminal until reset and accepts no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 13 | Trigger request lines, index = priority (0 highest) |
| mask_clr_i | input | 1 | Supply-monitor masks have been cleared |
| seq_done_i | input | 1 | Sequence engine finished the running sequence |
| seq_start_o | output | 1 | One-cycle start pulse to the sequence engine |
| seq_code_o | output | 4 | Code of the running sequence, 0 when idle |
| state_o | output | 3 | Current power state code |
| en_drv_o | output | 1 | External enable-driver line |
| dom_en_o | output | NGRP (8) | Power-domain group enables |

## Verification
The assertions assume that seq_done_i is a single-cycle pulse that only arrives while a sequence runs. They also assume that trigger lines are released before done, so that a held re-entrant trigger is not meant to restart. The stimulus follows this: every trigger is a one-cycle pulse and done is one cycle wide. The exceptions are the deferred-hold and preemption cases. There a line is held on purpose across busy cycles, and the expected restart or lack of restart is checked.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int NTRIG = 13;
  localparam int IDW   = $clog2(NTRIG);
  localparam int CODEW = $clog2(NTRIG + 1);

  typedef enum logic [2:0] {
    ST_STBY   = 3'd0,
    ST_ACT    = 3'd1,
    ST_MCU    = 3'd2,
    ST_SOCERR = 3'd3,
    ST_RET    = 3'd4,
    ST_SAFE   = 3'd5
  } pstate_e;

  localparam logic [IDW-1:0] T_SEVERE  = IDW'(0);
  localparam logic [IDW-1:0] T_MCUPWR  = IDW'(1);
  localparam logic [IDW-1:0] T_ORDERLY = IDW'(2);
  localparam logic [IDW-1:0] T_OFF     = IDW'(3);
  localparam logic [IDW-1:0] T_SOCPWR  = IDW'(4);
  localparam logic [IDW-1:0] T_WD_ACT  = IDW'(5);
  localparam logic [IDW-1:0] T_MERR_A  = IDW'(6);
  localparam logic [IDW-1:0] T_SERR_A  = IDW'(7);
  localparam logic [IDW-1:0] T_WD_MCU  = IDW'(8);
  localparam logic [IDW-1:0] T_MERR_M  = IDW'(9);
  localparam logic [IDW-1:0] T_TO_MCU  = IDW'(10);
  localparam logic [IDW-1:0] T_ON      = IDW'(11);
  localparam logic [IDW-1:0] T_TO_RET  = IDW'(12);
endpackage

// File: rtl/psc_prio_pick.sv
module psc_prio_pick #(
  parameter int N  = 13,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] id_o
);
  logic [N-1:0] lower_set;  // bit i: some line below i is asserted
  logic [N-1:0] win;

  assign lower_set[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign lower_set[i] = lower_set[i-1] | req_i[i-1];
  end
  for (genvar i = 0; i < N; i++) begin : g_win
    assign win[i] = req_i[i] & ~lower_set[i];
  end

  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) id_o = id_o | IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/psc_trig_rules.sv
module psc_trig_rules
  import psc_pkg::*;
(
  input  pstate_e        state_i,
  input  logic [IDW-1:0] id_i,
  input  logic           mask_clr_i,
  output logic           valid_o,
  output logic           imm_o,
  output pstate_e        dest_o
);
  logic legal, reent, mission;

  assign mission = (state_i == ST_STBY) || (state_i == ST_ACT) ||
                   (state_i == ST_MCU)  || (state_i == ST_RET);

  always_comb begin
    legal  = 1'b0;
    reent  = 1'b0;
    imm_o  = 1'b0;
    dest_o = state_i;
    case (id_i)
      T_SEVERE, T_MCUPWR, T_ORDERLY: begin
        legal = mission; imm_o = 1'b1; dest_o = ST_SAFE;
      end
      T_OFF:    begin legal = mission; dest_o = ST_STBY; end
      T_SOCPWR: begin legal = (state_i == ST_ACT); dest_o = ST_SOCERR; end
      T_WD_ACT, T_MERR_A, T_SERR_A: begin
        legal = (state_i == ST_ACT); reent = 1'b1; dest_o = ST_ACT;
      end
      T_WD_MCU, T_MERR_M: begin
        legal = (state_i == ST_MCU); reent = 1'b1; dest_o = ST_MCU;
      end
      T_TO_MCU: begin
        legal = (state_i == ST_ACT) || (state_i == ST_SOCERR); dest_o = ST_MCU;
      end
      T_ON: begin
        legal  = mask_clr_i && ((state_i == ST_STBY) || (state_i == ST_MCU) ||
                                (state_i == ST_RET));
        dest_o = ST_ACT;
      end
      T_TO_RET: begin legal = (state_i == ST_ACT); dest_o = ST_RET; end
      default: ;
    endcase
  end

  // non-re-entrant triggers are dropped when already at destination
  assign valid_o = legal && (reent || (dest_o != state_i));
endmodule

// File: rtl/psc_pwr_decode.sv
module psc_pwr_decode
  import psc_pkg::*;
#(
  parameter int              NGRP         = 8,
  parameter logic [NGRP-1:0] MCU_GRP_MASK = NGRP'(8'h03),
  parameter logic [NGRP-1:0] DDR_GRP_MASK = NGRP'(8'h1C)
) (
  input  pstate_e         state_i,
  input  logic            safe_exit_i,
  output logic            en_drv_o,
  output logic [NGRP-1:0] dom_en_o
);
  always_comb begin
    en_drv_o = 1'b0;
    dom_en_o = '0;
    if (!safe_exit_i) begin
      case (state_i)
        ST_ACT:            begin en_drv_o = 1'b1; dom_en_o = '1; end
        ST_MCU, ST_SOCERR: begin en_drv_o = 1'b1; dom_en_o = MCU_GRP_MASK; end
        ST_RET:            dom_en_o = DDR_GRP_MASK;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import psc_pkg::*;
#(
  parameter int              NGRP         = 8,
  parameter logic [NGRP-1:0] MCU_GRP_MASK = NGRP'(8'h03),
  parameter logic [NGRP-1:0] DDR_GRP_MASK = NGRP'(8'h1C)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTRIG-1:0] trig_i,
  input  logic             mask_clr_i,
  input  logic             seq_done_i,
  output logic             seq_start_o,
  output logic [CODEW-1:0] seq_code_o,
  output logic [2:0]       state_o,
  output logic             en_drv_o,
  output logic [NGRP-1:0]  dom_en_o
);
  pstate_e        state_q, tgt_q, dest;
  logic           busy_q, start_q, safe_q;
  logic [IDW-1:0] run_id_q, pick_id;
  logic [CODEW-1:0] code_q;
  logic           pick_any, valid, imm, cand, preempt, launch;

  psc_prio_pick #(.N(NTRIG), .IW(IDW)) u_pick (
    .req_i(trig_i), .any_o(pick_any), .id_o(pick_id)
  );

  psc_trig_rules u_rules (
    .state_i(state_q), .id_i(pick_id), .mask_clr_i(mask_clr_i),
    .valid_o(valid), .imm_o(imm), .dest_o(dest)
  );

  assign cand    = pick_any && valid;
  assign preempt = busy_q && cand && imm && (pick_id < run_id_q);
  assign launch  = cand && (!busy_q || preempt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_STBY;
      tgt_q    <= ST_STBY;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      safe_q   <= 1'b0;
      run_id_q <= '0;
      code_q   <= '0;
    end else begin
      start_q <= launch;
      if (launch) begin
        busy_q   <= 1'b1;
        run_id_q <= pick_id;
        tgt_q    <= dest;
        code_q   <= CODEW'(pick_id) + CODEW'(1);
        if (dest == ST_SAFE) safe_q <= 1'b1;
      end else if (busy_q && seq_done_i) begin
        busy_q  <= 1'b0;
        state_q <= tgt_q;
        code_q  <= '0;
      end
    end
  end

  psc_pwr_decode #(
    .NGRP(NGRP), .MCU_GRP_MASK(MCU_GRP_MASK), .DDR_GRP_MASK(DDR_GRP_MASK)
  ) u_dec (
    .state_i(state_q), .safe_exit_i(safe_q),
    .en_drv_o(en_drv_o), .dom_en_o(dom_en_o)
  );

  assign seq_start_o = start_q;
  assign seq_code_o  = code_q;
  assign state_o     = state_q;

  p_state_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && seq_done_i) |=> $stable(state_q));
  p_code_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (seq_code_o == '0) && !seq_start_o);
  p_hold_deferred_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !preempt) |=> !seq_start_o);
  p_abort_higher_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && launch) |-> (pick_id < run_id_q) && imm);
  p_ret_groups_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RET && !safe_q) |-> !en_drv_o && (dom_en_o == DDR_GRP_MASK));
  p_safe_dark_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_q |-> !en_drv_o && (dom_en_o == '0));
  p_safe_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAFE) |=> (state_q == ST_SAFE) && !seq_start_o);
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  localparam int NT = 13;
  localparam int NV = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NT-1:0] trig_i = '0;
  logic          mask_clr_i = 1'b0;
  logic          seq_done_i = 1'b0;
  logic          seq_start_o, en_drv_o;
  logic [3:0]    seq_code_o;
  logic [2:0]    state_o;
  logic [7:0]    dom_en_o;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk_i = ~clk_i;

  pwr_seq_ctrl u_pwr_seq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .mask_clr_i(mask_clr_i),
    .seq_done_i(seq_done_i), .seq_start_o(seq_start_o), .seq_code_o(seq_code_o),
    .state_o(state_o), .en_drv_o(en_drv_o), .dom_en_o(dom_en_o)
  );

  // {trig[29:17], mask[16], code[15:12] (0 = no start), state[11:9], en[8], dom[7:0]}
  localparam logic [29:0] VEC [NV] = '{
    {13'h0800, 1'b0, 4'd0,  3'd0, 1'b0, 8'h00}, // R7 on blocked by masks
    {13'h0800, 1'b1, 4'd12, 3'd1, 1'b1, 8'hFF}, // R7 on -> ACTIVE
    {13'h0020, 1'b1, 4'd6,  3'd1, 1'b1, 8'hFF}, // R5 wdog in ACTIVE
    {13'h0080, 1'b1, 4'd8,  3'd1, 1'b1, 8'hFF}, // R5 soc error signal
    {13'h0400, 1'b1, 4'd11, 3'd2, 1'b1, 8'h03}, // R6 ACTIVE -> MCU_ONLY
    {13'h0100, 1'b1, 4'd9,  3'd2, 1'b1, 8'h03}, // R5 wdog in MCU_ONLY
    {13'h0200, 1'b1, 4'd10, 3'd2, 1'b1, 8'h03}, // R5 mcu error in MCU_ONLY
    {13'h0020, 1'b1, 4'd0,  3'd2, 1'b1, 8'h03}, // R5 ACTIVE wdog illegal here
    {13'h0800, 1'b1, 4'd12, 3'd1, 1'b1, 8'hFF}, // R7 MCU_ONLY -> ACTIVE
    {13'h0010, 1'b1, 4'd5,  3'd3, 1'b1, 8'h03}, // R6 -> SOC_PWR_ERROR
    {13'h0001, 1'b1, 4'd0,  3'd3, 1'b1, 8'h03}, // R6 severe not accepted
    {13'h0008, 1'b1, 4'd0,  3'd3, 1'b1, 8'h03}, // R6 off not accepted
    {13'h0400, 1'b1, 4'd11, 3'd2, 1'b1, 8'h03}, // R6 return to MCU_ONLY
    {13'h0800, 1'b1, 4'd12, 3'd1, 1'b1, 8'hFF}, // R7
    {13'h1000, 1'b1, 4'd13, 3'd4, 1'b0, 8'h1C}, // R7 -> RETENTION, R11
    {13'h0800, 1'b1, 4'd12, 3'd1, 1'b1, 8'hFF}, // R7 RETENTION -> ACTIVE
    {13'h0008, 1'b1, 4'd4,  3'd0, 1'b0, 8'h00}, // R4 off -> STANDBY
    {13'h0008, 1'b1, 4'd0,  3'd0, 1'b0, 8'h00}, // R4 not re-entrant
    {13'h0800, 1'b1, 4'd12, 3'd1, 1'b1, 8'hFF}, // R7
    {13'h1100, 1'b1, 4'd0,  3'd1, 1'b1, 8'hFF}, // R2 id 8 blocks id 12
    {13'h0030, 1'b1, 4'd5,  3'd3, 1'b1, 8'h03}, // R2 id 4 beats id 5
    {13'h0400, 1'b1, 4'd11, 3'd2, 1'b1, 8'h03}, // R6
    {13'h0800, 1'b1, 4'd12, 3'd1, 1'b1, 8'hFF}, // R7
    {13'h0040, 1'b1, 4'd7,  3'd1, 1'b1, 8'hFF}  // R5 mcu error in ACTIVE
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nedge();
    @(negedge clk_i);
  endtask

  task automatic chk_out(input string tag, input int st, input int en, input int dom);
    chk({tag, " state"}, int'(state_o), st);
    chk("R11 en_drv", int'(en_drv_o), en);
    chk("R11 dom_en", int'(dom_en_o), dom);
  endtask

  task automatic pulse(input int bitn);
    nedge(); trig_i = NT'(1) << bitn;
    nedge(); trig_i = '0;
  endtask

  task automatic finish_done();
    seq_done_i = 1'b1; nedge(); seq_done_i = 1'b0;
  endtask

  initial begin
    #(5 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (3) nedge();
    rst_ni = 1'b1;
    nedge();
    // R1 reset state
    chk("R1 seq_start", int'(seq_start_o), 0);
    chk("R1 seq_code", int'(seq_code_o), 0);
    chk_out("R1", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      nedge();
      trig_i = v[29:17]; mask_clr_i = v[16];
      nedge();
      trig_i = '0;
      chk("R8 seq_start", int'(seq_start_o), int'(v[15:12] != 0));
      chk("R8 seq_code", int'(seq_code_o), int'(v[15:12]));
      if (v[15:12] != 0) finish_done();
      chk("R8 seq_code idle", int'(seq_code_o), 0);
      chk_out("R8", int'(v[11:9]), int'(v[8]), int'(v[7:0]));
    end

    // R9 deferred trigger held during a running sequence (state ACTIVE)
    nedge(); trig_i = NT'(1) << 5;
    nedge(); trig_i = NT'(1) << 12;
    chk("R9 first start", int'(seq_code_o), 6);
    nedge();
    chk("R9 no start while busy", int'(seq_start_o), 0);
    chk("R9 code held", int'(seq_code_o), 6);
    finish_done();
    chk("R9 no start at done", int'(seq_start_o), 0);
    chk("R9 state", int'(state_o), 1);
    nedge(); trig_i = '0;
    chk("R9 start after done", int'(seq_start_o), 1);
    chk("R9 code", int'(seq_code_o), 13);
    finish_done();
    chk_out("R9", 4, 0, 8'h1C);
    pulse(11); finish_done();
    chk_out("R7", 1, 1, 8'hFF);

    // R10 / R12 immediate preemption chain
    nedge(); trig_i = NT'(1) << 12;
    nedge(); trig_i = NT'(1) << 2;
    chk("R10 ret start", int'(seq_code_o), 13);
    nedge(); trig_i = NT'(1) << 0;
    chk("R10 orderly preempts", int'(seq_start_o), 1);
    chk("R3 orderly code", int'(seq_code_o), 3);
    chk("R10 state kept", int'(state_o), 1);
    chk("R12 en_drv dark", int'(en_drv_o), 0);
    chk("R12 dom dark", int'(dom_en_o), 0);
    nedge(); trig_i = NT'(1) << 1;
    chk("R3 severe code", int'(seq_code_o), 1);
    nedge(); trig_i = '0;
    chk("R10 lower immediate ignored", int'(seq_start_o), 0);
    chk("R10 code kept", int'(seq_code_o), 1);
    finish_done();
    chk_out("R3", 5, 0, 0);
    nedge(); trig_i = NT'(1) << 11;
    nedge(); trig_i = NT'(1) << 3;
    nedge(); trig_i = '0;
    chk("R12 no start in SAFE", int'(seq_start_o), 0);
    chk("R12 state SAFE", int'(state_o), 5);

    // R1 reset again
    rst_ni = 1'b0;
    nedge();
    rst_ni = 1'b1;
    nedge();
    chk("R1 seq_code", int'(seq_code_o), 0);
    chk_out("R1", 0, 0, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end
endmodule